// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Register

This block holds a parallel word in a capture register and hands it, on request, to a serializing shift chain. Each bit of the chain leaves through one serial output. A capture strobe samples the parallel input into the capture register. That register can be refilled while the shift chain is still emptying the previous word, so the next word can be prepared while the current one goes out.

The shift chain is controlled by a one-cycle shift strobe and by two level controls, both active low. The transfer control copies the capture register into the chain. The flush control zeroes the chain. Both level controls are sampled on every clock and take precedence over shifting. When flush and transfer are asserted together the request is malformed. The block resolves it in favour of flush and raises a sticky conflict flag.

A synchronous reset clears both registers and the flag. Everything runs on one system clock.

Top module: `buffered_piso`

## Requirements
- R1: While `srst` is high at a clock edge, the capture register, every shift stage and `conflict_err` become 0 after that edge.
- R2: On an edge with `cap_stb` high, the capture register takes `par_in`; with `cap_stb` low it keeps its value. Capture alone never changes the shift chain.
- R3: On an edge with `clear_n` and `load_n` both high and `shf_stb` high, stage 0 takes `ser_in` and stage n takes the previous value of stage n-1.
- R4: `ser_out` always shows the highest stage (stage WIDTH-1) of the shift chain.
- R5: On an edge with `load_n` low and `clear_n` high, the chain takes the capture register's contents, whatever `shf_stb` is. Bit k of the word goes to stage k.
- R6: When `cap_stb` is high on the same edge that R5 applies, the chain takes the new `par_in` word rather than the old stored one.
- R7: On an edge with `clear_n` low, every stage becomes 0, overriding load and shift. The capture register is untouched.
- R8: When `clear_n` and `load_n` are low on the same edge, the chain clears as in R7 and `conflict_err` goes to 1. It stays 1 until the next reset.
- R9: On an edge with `clear_n` and `load_n` high and `shf_stb` low, the chain holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel word to capture |
| cap_stb | input | 1 | One-cycle capture enable |
| shf_stb | input | 1 | One-cycle shift enable |
| load_n | input | 1 | Transfer capture register into chain, active low, level |
| clear_n | input | 1 | Zero the shift chain, active low, level |
| ser_in | input | 1 | Serial bit entering stage 0 |
| ser_out | output | 1 | Highest shift stage |
| conflict_err | output | 1 | Sticky flag for simultaneous clear and load |

## Verification
The functions that can coincide are capture and transfer (R6) and flush and transfer (R8). Shifting can also fall in the same cycle as a transfer or a flush (R5, R7). The bench drives these pairs in a single cycle, and it first places a different word in the capture register so that old and new data can be told apart. The result is judged by shifting the whole chain out through `ser_out` and comparing each bit against a queue of expected bits. A later transfer, made with no capture, shows whether the flush left the capture register intact.

// File: rtl/bpiso_pkg.sv
package bpiso_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } chain_op_e;

endpackage

// File: rtl/bpiso_store.sv
module bpiso_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             cap_stb,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] store_q
);

   always_ff @(posedge clk) begin
      if (srst)
         store_q <= '0;
      else if (cap_stb)
         store_q <= par_in;
   end

endmodule

// File: rtl/bpiso_ctrl.sv
module bpiso_ctrl
   import bpiso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             cap_stb,
   input  logic             shf_stb,
   input  logic             load_n,
   input  logic             clear_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic [WIDTH-1:0] store_q,
   output chain_op_e        op,
   output logic [WIDTH-1:0] load_word,
   output logic             conflict_err
);

   logic clr_req;
   logic ld_req;

   assign clr_req = ~clear_n;
   assign ld_req  = ~load_n;

   // priority: clear, load, shift, hold
   always_comb begin
      if (clr_req)
         op = OP_CLEAR;
      else if (ld_req)
         op = OP_LOAD;
      else if (shf_stb)
         op = OP_SHIFT;
      else
         op = OP_HOLD;
   end

   // a word captured in the same cycle bypasses the capture register
   assign load_word = cap_stb ? par_in : store_q;

   always_ff @(posedge clk) begin
      if (srst)
         conflict_err <= 1'b0;
      else if (clr_req && ld_req)
         conflict_err <= 1'b1;
   end

endmodule

// File: rtl/bpiso_chain.sv
module bpiso_chain
   import bpiso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  chain_op_e        op,
   input  logic [WIDTH-1:0] load_word,
   input  logic             ser_in,
   output logic [WIDTH-1:0] sh_q
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic shift_src;
      logic stage_q;

      if (i == 0) begin : g_head
         assign shift_src = ser_in;
      end else begin : g_body
         assign shift_src = sh_q[i-1];
      end

      always_ff @(posedge clk) begin
         if (srst)
            stage_q <= 1'b0;
         else begin
            case (op)
               OP_CLEAR: stage_q <= 1'b0;
               OP_LOAD:  stage_q <= load_word[i];
               OP_SHIFT: stage_q <= shift_src;
               default:  stage_q <= stage_q;
            endcase
         end
      end

      assign sh_q[i] = stage_q;
   end

endmodule

// File: rtl/buffered_piso.sv
module buffered_piso
   import bpiso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic [WIDTH-1:0] par_in,
   input  logic             cap_stb,
   input  logic             shf_stb,
   input  logic             load_n,
   input  logic             clear_n,
   input  logic             ser_in,
   output logic             ser_out,
   output logic             conflict_err
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("buffered_piso: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] store_q;
   logic [WIDTH-1:0] load_word;
   logic [WIDTH-1:0] sh_q;
   chain_op_e        op;

   bpiso_store #(.WIDTH(WIDTH)) store_i (
      .clk     (clk),
      .srst    (srst),
      .cap_stb (cap_stb),
      .par_in  (par_in),
      .store_q (store_q)
   );

   bpiso_ctrl #(.WIDTH(WIDTH)) ctrl_i (
      .clk          (clk),
      .srst         (srst),
      .cap_stb      (cap_stb),
      .shf_stb      (shf_stb),
      .load_n       (load_n),
      .clear_n      (clear_n),
      .par_in       (par_in),
      .store_q      (store_q),
      .op           (op),
      .load_word    (load_word),
      .conflict_err (conflict_err)
   );

   bpiso_chain #(.WIDTH(WIDTH)) chain_i (
      .clk       (clk),
      .srst      (srst),
      .op        (op),
      .load_word (load_word),
      .ser_in    (ser_in),
      .sh_q      (sh_q)
   );

   assign ser_out = sh_q[MSB];

endmodule

// File: rtl/buffered_piso_chk.sv
module buffered_piso_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             srst,
   input logic [WIDTH-1:0] par_in,
   input logic             cap_stb,
   input logic             shf_stb,
   input logic             load_n,
   input logic             clear_n,
   input logic             ser_in,
   input logic             ser_out,
   input logic             conflict_err,
   input logic [WIDTH-1:0] store_q,
   input logic [WIDTH-1:0] sh_q
);

   // R2
   capture_take_chk: assert property (@(posedge clk) disable iff (srst)
      cap_stb |=> store_q == $past(par_in));

   // R2
   capture_keep_chk: assert property (@(posedge clk) disable iff (srst)
      !cap_stb |=> $stable(store_q));

   // R3
   shift_step_chk: assert property (@(posedge clk) disable iff (srst)
      (clear_n && load_n && shf_stb) |=>
         sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

   // R4
   out_tap_chk: assert property (@(posedge clk) disable iff (srst)
      ser_out == sh_q[WIDTH-1]);

   // R5
   load_old_chk: assert property (@(posedge clk) disable iff (srst)
      (clear_n && !load_n && !cap_stb) |=> sh_q == $past(store_q));

   // R6
   load_new_chk: assert property (@(posedge clk) disable iff (srst)
      (clear_n && !load_n && cap_stb) |=> sh_q == $past(par_in));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (srst)
      !clear_n |=> sh_q == '0);

   // R8
   conflict_set_chk: assert property (@(posedge clk) disable iff (srst)
      (!clear_n && !load_n) |=> conflict_err);

   // R8
   conflict_sticky_chk: assert property (@(posedge clk) disable iff (srst)
      conflict_err |=> conflict_err);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (srst)
      (clear_n && load_n && !shf_stb) |=> $stable(sh_q));

endmodule

bind buffered_piso buffered_piso_chk #(.WIDTH(WIDTH)) chk_i (
   .clk          (clk),
   .srst         (srst),
   .par_in       (par_in),
   .cap_stb      (cap_stb),
   .shf_stb      (shf_stb),
   .load_n       (load_n),
   .clear_n      (clear_n),
   .ser_in       (ser_in),
   .ser_out      (ser_out),
   .conflict_err (conflict_err),
   .store_q      (store_q),
   .sh_q         (sh_q)
);

// File: tb/buffered_piso_tb_top.sv
module buffered_piso_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int WDOG_CYC   = 5000;

   typedef struct {
      logic  out_bit;
      logic  err_bit;
      string req;
   } exp_t;

   logic         clk = 1'b0;
   logic         srst = 1'b1;
   logic [W-1:0] par_in = '0;
   logic         cap_stb = 1'b0;
   logic         shf_stb = 1'b0;
   logic         load_n = 1'b1;
   logic         clear_n = 1'b1;
   logic         ser_in = 1'b0;
   logic         ser_out;
   logic         conflict_err;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   // bench model, built from the requirements
   logic [W-1:0] m_store = '0;
   logic [W-1:0] m_sh = '0;
   logic         m_err = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   buffered_piso #(.WIDTH(W)) dut_i (
      .clk          (clk),
      .srst         (srst),
      .par_in       (par_in),
      .cap_stb      (cap_stb),
      .shf_stb      (shf_stb),
      .load_n       (load_n),
      .clear_n      (clear_n),
      .ser_in       (ser_in),
      .ser_out      (ser_out),
      .conflict_err (conflict_err)
   );

   // driver: one clock per call, expected post-edge outputs queued
   task automatic step(input logic rst, input logic cap, input logic shf,
                       input logic ldn, input logic clrn, input logic sin,
                       input logic [W-1:0] pin, input string req);
      exp_t e;
      @(negedge clk);
      srst = rst; cap_stb = cap; shf_stb = shf;
      load_n = ldn; clear_n = clrn; ser_in = sin; par_in = pin;
      if (rst) begin
         m_store = '0; m_sh = '0; m_err = 1'b0;
      end else begin
         if (!clrn && !ldn) m_err = 1'b1;
         if (!clrn)          m_sh = '0;
         else if (!ldn)      m_sh = cap ? pin : m_store;
         else if (shf)       m_sh = {m_sh[W-2:0], sin};
         if (cap) m_store = pin;
      end
      e.out_bit = m_sh[W-1];
      e.err_bit = m_err;
      e.req     = req;
      sb_q.push_back(e);
   endtask

   task automatic idle(input string req);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, req);
   endtask

   task automatic shift_out(input int n, input logic [W-1:0] fill, input string req);
      for (int i = 0; i < n; i++)
         step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, fill[i % W], 8'h00, req);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (ser_out !== e.out_bit || conflict_err !== e.err_bit) begin
               errors++;
               $display("FAIL %s: ser_out/err actual %b/%b expected %b/%b",
                        e.req, ser_out, conflict_err, e.out_bit, e.err_bit);
            end
         end
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R1 reset");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, "R1 reset over strobes");
      // R2 capture alone leaves chain at zero
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R2 capture only");
      idle("R9 hold");
      // R5 transfer, then R3/R4 shift whole word out
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R5 load stored");
      shift_out(W, 8'b0110_1001, "R3 R4 shift out A5");
      // R5 load overrides a shift strobe
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R5 load over shift");
      shift_out(W, 8'h00, "R5 verify reload");
      // R6 capture and load together take the new word
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, "R6 capture+load");
      idle("R9 hold after load");
      shift_out(W, 8'hFF, "R6 shift new word");
      // R2 capture register now holds 3C; put 81 in, leave chain alone
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, "R2 capture during shift");
      // R7 clear overriding shift, storage intact
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R7 clear over shift");
      idle("R7 stays clear");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7 storage kept");
      shift_out(W, 8'h00, "R7 verify storage 81");
      // R8 clear and load together
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R8 preload");
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R8 conflict clears");
      idle("R8 flag sticky");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R8 flag sticky after load");
      shift_out(3, 8'h05, "R8 flag sticky while shifting");
      // R1 reset clears flag and both registers
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R1 reset clears flag");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R1 storage zero after reset");
      shift_out(W, 8'h00, "R1 chain zero after reset");
      idle("R9 final hold");
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/2);
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule